// File: doc/BRIEF.md
# Two-Coin Drink Vendor Controller

A clocked controller for a drink vendor that takes exactly two quarter coins per purchase and offers three products. Each coin arrives as a one-cycle pulse. The controller counts credit until the price is reached. It then waits for a product-select pulse and issues a one-cycle dispense pulse for the chosen product. After that it holds until the customer removes the bottle.

A stuck-bottle sensor takes priority over every other input and every state. While that sensor is active, the controller stays in a lockout state that refuses coins, selections and bottle-taken events. A clear pulse ends the lockout. The controller then goes back to collecting money with zero credit, so any credit inserted before the jam is lost. Coin validation, change return and motor drive belong to other blocks.

Top module: `vend_ctrl`

## Requirements
- R1: After reset, `credit_o` is 0, and `dispense_o`, `ready_o`, `take_wait_o` and `locked_o` are all low.
- R2: A coin pulse while collecting raises `credit_o` by one on the next cycle. When the count reaches the price (default 2 coins), `ready_o` is high from that cycle on.
- R3: While `ready_o` is high, a select pulse produces a one-cycle pulse on the matching `dispense_o` bit on the next cycle (bit 0 cola, bit 1 diet cola, bit 2 lemon-lime). `credit_o` is 0 from that cycle on.
- R4: If several `sel_i` bits are high in the same accepted cycle, only the lowest-numbered product is dispensed.
- R5: In the cycle after a dispense pulse, `take_wait_o` goes high. It stays high until `taken_i` is sampled, and one cycle later the controller is collecting again with credit 0.
- R6: Select pulses sampled below full credit are ignored: no dispense pulse, and the credit is unchanged.
- R7: Coin pulses at full credit, during a dispense and while waiting for the bottle to be taken are ignored: the credit does not change.
- R8: `jam_i` sampled in any state makes `locked_o` high on the next cycle, with `credit_o` 0 and no dispense.
- R9: While locked, coin, select and bottle-taken pulses have no effect, and the controller stays locked.
- R10: `clear_i` sampled while locked with `jam_i` low returns the controller to collecting with credit 0 on the next cycle. If `jam_i` is high at the same time, the controller stays locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coin_i | input | 1 | One-cycle pulse per quarter coin |
| sel_i | input | 3 | Product select pulses, one bit per product |
| taken_i | input | 1 | Bottle removed |
| jam_i | input | 1 | Stuck-bottle sensor |
| clear_i | input | 1 | Jam cleared |
| dispense_o | output | 3 | One-cycle dispense pulse per product |
| credit_o | output | 2 | Coins currently credited |
| ready_o | output | 1 | Price reached, waiting for a selection |
| take_wait_o | output | 1 | Waiting for the bottle to be removed |
| locked_o | output | 1 | Jam lockout active |

## Verification
The assertions assume that every input is synchronous to `clk_i` and stable around the sampling edge. They also assume that each input is judged only by its value at that edge, so a select that is held high for several cycles counts as a fresh select in every cycle. The bench drives all inputs on the falling edge and holds each stimulus for exactly one cycle. It includes jam overlapping clear and several selects in the same cycle, because the priority rules define these combinations.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef enum logic [2:0] {
    ST_COLLECT = 3'd0,
    ST_READY   = 3'd1,
    ST_DISP    = 3'd2,
    ST_TAKE    = 3'd3,
    ST_STUCK   = 3'd4
  } vend_state_e;
endpackage

// File: rtl/vend_sel_pick.sv
module vend_sel_pick #(
  parameter int NUM_PROD = 3,
  localparam int PW = (NUM_PROD > 1) ? $clog2(NUM_PROD) : 1
) (
  input  logic [NUM_PROD-1:0] sel_i,
  output logic                valid_o,
  output logic [PW-1:0]       idx_o
);
  // lowest index wins: scan from the top so the lowest hit overwrites
  always_comb begin
    idx_o = '0;
    for (int i = NUM_PROD - 1; i >= 0; i--) begin
      if (sel_i[i]) idx_o = PW'(i);
    end
  end
  assign valid_o = |sel_i;
endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
  import vend_pkg::*;
#(
  parameter int NUM_PROD = 3,
  parameter int PRICE    = 2,
  localparam int PW = (NUM_PROD > 1) ? $clog2(NUM_PROD) : 1,
  localparam int CW = $clog2(PRICE + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          coin_i,
  input  logic          sel_vld_i,
  input  logic [PW-1:0] sel_idx_i,
  input  logic          taken_i,
  input  logic          jam_i,
  input  logic          clear_i,
  output vend_state_e   state_o,
  output logic [PW-1:0] prod_o,
  output logic [CW-1:0] credit_o
);
  vend_state_e   state_q, state_d;
  logic [PW-1:0] prod_q, prod_d;
  logic [CW-1:0] credit_q, credit_d;

  always_comb begin
    state_d  = state_q;
    prod_d   = prod_q;
    credit_d = credit_q;
    if (jam_i) begin
      state_d  = ST_STUCK;
      credit_d = '0;
    end else begin
      unique case (state_q)
        ST_COLLECT: if (coin_i) begin
          credit_d = credit_q + 1'b1;
          if (credit_q + 1'b1 == CW'(PRICE)) state_d = ST_READY;
        end
        ST_READY: if (sel_vld_i) begin
          state_d  = ST_DISP;
          prod_d   = sel_idx_i;
          credit_d = '0;
        end
        ST_DISP:  state_d = ST_TAKE;
        ST_TAKE:  if (taken_i) state_d = ST_COLLECT;
        ST_STUCK: if (clear_i) begin
          state_d  = ST_COLLECT;
          credit_d = '0;
        end
        default: begin
          state_d  = ST_COLLECT;
          credit_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_COLLECT;
      prod_q   <= '0;
      credit_q <= '0;
    end else begin
      state_q  <= state_d;
      prod_q   <= prod_d;
      credit_q <= credit_d;
    end
  end

  assign state_o  = state_q;
  assign prod_o   = prod_q;
  assign credit_o = credit_q;

  // R8
  jam_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jam_i |=> (state_q == ST_STUCK && credit_q == '0));
  // R3
  sel_dispenses_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READY && sel_vld_i && !jam_i) |=> (state_q == ST_DISP && prod_q == $past(sel_idx_i)));
  // R6
  early_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COLLECT && !coin_i && !jam_i) |=> (state_q == ST_COLLECT && $stable(credit_q)));
  // R5
  take_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TAKE && taken_i && !jam_i) |=> (state_q == ST_COLLECT && credit_q == '0));
  // R10
  clear_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STUCK && clear_i && !jam_i) |=> (state_q == ST_COLLECT && credit_q == '0));
  // R9
  stuck_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STUCK && !clear_i) |=> state_q == ST_STUCK);
endmodule

// File: rtl/vend_out_dec.sv
module vend_out_dec
  import vend_pkg::*;
#(
  parameter int NUM_PROD = 3,
  localparam int PW = (NUM_PROD > 1) ? $clog2(NUM_PROD) : 1
) (
  input  vend_state_e         state_i,
  input  logic [PW-1:0]       prod_i,
  output logic [NUM_PROD-1:0] dispense_o,
  output logic                ready_o,
  output logic                take_wait_o,
  output logic                locked_o
);
  for (genvar g = 0; g < NUM_PROD; g++) begin : g_disp
    assign dispense_o[g] = (state_i == ST_DISP) && (prod_i == PW'(g));
  end
  assign ready_o     = state_i == ST_READY;
  assign take_wait_o = state_i == ST_TAKE;
  assign locked_o    = state_i == ST_STUCK;
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int NUM_PROD = 3,
  parameter int PRICE    = 2,
  localparam int PW = (NUM_PROD > 1) ? $clog2(NUM_PROD) : 1,
  localparam int CW = $clog2(PRICE + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                coin_i,
  input  logic [NUM_PROD-1:0] sel_i,
  input  logic                taken_i,
  input  logic                jam_i,
  input  logic                clear_i,
  output logic [NUM_PROD-1:0] dispense_o,
  output logic [CW-1:0]       credit_o,
  output logic                ready_o,
  output logic                take_wait_o,
  output logic                locked_o
);
  logic          sel_vld;
  logic [PW-1:0] sel_idx;
  vend_state_e   state;
  logic [PW-1:0] prod;

  vend_sel_pick #(.NUM_PROD(NUM_PROD)) u_pick (
    .sel_i(sel_i), .valid_o(sel_vld), .idx_o(sel_idx)
  );

  vend_fsm #(.NUM_PROD(NUM_PROD), .PRICE(PRICE)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .coin_i(coin_i),
    .sel_vld_i(sel_vld), .sel_idx_i(sel_idx), .taken_i(taken_i),
    .jam_i(jam_i), .clear_i(clear_i),
    .state_o(state), .prod_o(prod), .credit_o(credit_o)
  );

  vend_out_dec #(.NUM_PROD(NUM_PROD)) u_out (
    .state_i(state), .prod_i(prod), .dispense_o(dispense_o),
    .ready_o(ready_o), .take_wait_o(take_wait_o), .locked_o(locked_o)
  );

  // R3
  disp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dispense_o != '0) |=> (dispense_o == '0));
  // R4
  disp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dispense_o));
endmodule

// File: tb/vend_ctrl_tb_top.sv
module vend_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       coin = 1'b0, taken = 1'b0, jam = 1'b0, clr = 1'b0;
  logic [2:0] sel = '0;
  logic [2:0] disp;
  logic [1:0] credit;
  logic       ready, twait, locked;

  int errors = 0, checks = 0;
  // model: 0 collect, 1 ready, 2 dispense, 3 take, 4 stuck
  int m_kind = 0, m_credit = 0, m_prod = 0;

  always #4 clk = ~clk;

  vend_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .coin_i(coin), .sel_i(sel), .taken_i(taken),
    .jam_i(jam), .clear_i(clr), .dispense_o(disp), .credit_o(credit),
    .ready_o(ready), .take_wait_o(twait), .locked_o(locked)
  );

  task automatic compare(string req);
    logic [2:0] e_disp;
    logic [6:0] got, exp;
    e_disp = (m_kind == 2) ? 3'(1 << m_prod) : 3'b000;
    exp = {e_disp, 2'(m_credit), m_kind == 1, m_kind == 3};
    got = {disp, credit, ready, twait};
    checks++;
    if (got != exp || locked != (m_kind == 4)) begin
      errors++;
      $display("FAIL %s: disp/credit/ready/twait/locked = %b/%0d/%b/%b/%b expected %b/%0d/%b/%b/%b",
               req, disp, credit, ready, twait, locked,
               e_disp, m_credit, m_kind == 1, m_kind == 3, m_kind == 4);
    end
  endtask

  // one cycle: drive at negedge, advance model, compare at next negedge
  task automatic cyc(bit c, bit [2:0] s, bit t, bit j, bit cl, string req);
    coin = c; sel = s; taken = t; jam = j; clr = cl;
    if (j) begin m_kind = 4; m_credit = 0; end
    else case (m_kind)
      0: if (c) begin m_credit++; if (m_credit == 2) m_kind = 1; end
      1: if (s != 0) begin
           m_kind = 2; m_credit = 0;
           m_prod = s[0] ? 0 : (s[1] ? 1 : 2);
         end
      2: m_kind = 3;
      3: if (t) m_kind = 0;
      4: if (cl) begin m_kind = 0; m_credit = 0; end
      default: m_kind = 0;
    endcase
    @(negedge clk);
    compare(req);
  endtask

  task automatic buy(bit [2:0] s, string req);
    cyc(1, 0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, 0, "R2");
    cyc(0, s, 0, 0, 0, req);
    cyc(0, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, "R5");
    cyc(0, 0, 1, 0, 0, "R5");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    buy(3'b001, "R3");
    buy(3'b010, "R3");
    buy(3'b100, "R3");

    // R6: early selects
    cyc(0, 3'b111, 0, 0, 0, "R6");
    cyc(1, 0, 0, 0, 0, "R2");
    cyc(0, 3'b100, 0, 0, 0, "R6");
    cyc(1, 0, 0, 0, 0, "R2");
    // R7: extra coin at full credit
    cyc(1, 0, 0, 0, 0, "R7");
    cyc(1, 0, 0, 0, 0, "R7");
    // R4: multiple selects
    cyc(0, 3'b110, 0, 0, 0, "R4");
    cyc(1, 0, 0, 0, 0, "R7");
    cyc(1, 0, 0, 0, 0, "R7");
    cyc(1, 0, 1, 0, 0, "R7");
    buy(3'b111, "R4");
    buy(3'b101, "R4");

    // R8: jam with partial credit
    cyc(1, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 1, 0, "R8");
    cyc(1, 3'b001, 1, 0, 0, "R9");
    cyc(1, 3'b010, 0, 0, 0, "R9");
    cyc(0, 0, 0, 1, 1, "R10");
    cyc(0, 0, 0, 0, 1, "R10");
    cyc(0, 3'b001, 0, 0, 0, "R10");
    // jam at ready
    cyc(1, 0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 1, 0, "R8");
    cyc(0, 0, 0, 0, 1, "R10");
    // jam during dispense
    cyc(1, 0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, 0, "R2");
    cyc(0, 3'b010, 0, 0, 0, "R3");
    cyc(0, 0, 0, 1, 0, "R8");
    cyc(0, 0, 1, 0, 0, "R9");
    cyc(0, 0, 0, 0, 1, "R10");
    // jam while waiting for take
    cyc(1, 0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, 0, "R2");
    cyc(0, 3'b100, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, "R5");
    cyc(0, 0, 1, 1, 0, "R8");
    cyc(0, 0, 0, 1, 0, "R8");
    cyc(0, 0, 0, 0, 1, "R10");
    buy(3'b001, "R3");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule